// File: doc/BRIEF.md
# Transition-Coded Burst Link Controller

This block is the digital control for both ends of a pulse-based isolated data link. It does not send data levels across the barrier. It sends only the changes. Each time the transmit data changes, in either direction, the transmitter enables an external carrier oscillator for a fixed number of carrier periods. It then drives a clear strobe that damps the transmit tank, so that no stored energy rings on into the next symbol.

On the receive side, a detector output reports that a burst was seen. The controller toggles its recovered data level on each accepted detection. It also raises a front-end reset for a fixed number of clocks, so that a single burst is counted only once. Detections that arrive while that reset is active are ignored.

Both asynchronous inputs are synchronised to the block clock. The asynchronous reset is released synchronously. At reset the recovered level and the transmitter's last-sent level are both zero, so the two ends agree at start-up. The channel speed parameter selects a three-period burst (fast channel) or a two-period burst (slow channel).

Top module: `edge_burst_link`

## Requirements
- R1: While reset is active, and after it is released, `osc_en`, `tx_clr`, `rx_rst` and `data_out` are 0. The last-sent level starts at 0, so a `data_in` held at 0 produces no burst.
- R2: A rising or a falling change of `data_in` raises `osc_en` after the third rising clock edge that samples the new level, when the transmitter is idle. The delay is SYNC_STAGES+1 edges, with SYNC_STAGES=2.
- R3: Each burst keeps `osc_en` high for a contiguous run of CLKS_PER_CARRIER × 3 clocks when FAST_CHANNEL=1, or CLKS_PER_CARRIER × 2 clocks when FAST_CHANNEL=0.
- R4: `tx_clr` goes high in the cycle right after `osc_en` falls and stays high for CLR_CLKS clocks. `osc_en` and `tx_clr` are never high together.
- R5: A `data_in` change that arrives during a burst or a clear interval is held. After the clear interval, one idle cycle follows. A new burst then starts if the synchronised level differs from the last-sent level. Changes that cancel out before then send nothing.
- R6: A detector high that the receiver samples while `rx_rst` is low raises `rx_rst` after the third rising edge (SYNC_STAGES+1). `rx_rst` then stays high for RX_RST_CLKS clocks. A detector level still high after that window is counted again.
- R7: `data_out` inverts in the same cycle in which `rx_rst` rises, and changes at no other time.
- R8: Detector highs sampled while `rx_rst` is high have no effect. They cause no toggle of `data_out` and do not extend `rx_rst`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| data_in | input | 1 | Transmit data level (asynchronous) |
| osc_en | output | 1 | Carrier oscillator gate, registered |
| tx_clr | output | 1 | Transmit tank clear strobe, registered |
| det_in | input | 1 | Receive burst detector output (asynchronous) |
| rx_rst | output | 1 | Receive front-end reset pulse, registered |
| data_out | output | 1 | Recovered data level |

## Verification
The bench builds two copies of the block. Both use CLKS_PER_CARRIER=4, CLR_CLKS=4, RX_RST_CLKS=6 and SYNC_STAGES=2. One copy uses FAST_CHANNEL=1 and the other FAST_CHANNEL=0, so the 12-clock and 8-clock burst lengths are checked side by side against the same stimulus. With these short windows, the corner cases take only tens of cycles to reach:
- a data change landing inside a burst;
- a change that reverts before the transmitter is idle;
- a second detection inside the receive lockout;
- a detector held past the lockout.

// File: rtl/edge_burst_pkg.sv
package edge_burst_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_BURST = 2'd1,
    PH_FLUSH = 2'd2
  } tx_phase_e;

  function automatic int cnt_width(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/ebl_sync.sv
module ebl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  generate
    if (STAGES <= 1) begin : g_single
      logic stg_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= 1'b0;
        else        stg_q <= d;
      end
      assign q = stg_q;
    end else begin : g_chain
      logic [STAGES-1:0] stg_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= {stg_q[STAGES-2:0], d};
      end
      assign q = stg_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/ebl_tx.sv
module ebl_tx
  import edge_burst_pkg::*;
#(
  parameter int BURST_CLKS = 12,
  parameter int CLR_CLKS   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic data_s,
  output logic osc_en,
  output logic tx_clr
);

  localparam int TX_MAX = (BURST_CLKS > CLR_CLKS) ? BURST_CLKS : CLR_CLKS;
  localparam int CW     = cnt_width(TX_MAX);

  tx_phase_e       phase_q, phase_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            cnt_en;
  logic            sent_q, sent_d;
  logic            sent_en;
  logic            osc_q, clr_q;

  // next-state logic
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    sent_d  = sent_q;
    sent_en = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (data_s != sent_q) begin
          phase_d = PH_BURST;
          cnt_d   = CW'(BURST_CLKS - 1);
          cnt_en  = 1'b1;
          sent_d  = data_s;
          sent_en = 1'b1;
        end
      end
      PH_BURST: begin
        cnt_en = 1'b1;
        if (cnt_q == '0) begin
          phase_d = PH_FLUSH;
          cnt_d   = CW'(CLR_CLKS - 1);
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      PH_FLUSH: begin
        cnt_en = 1'b1;
        if (cnt_q == '0) phase_d = PH_IDLE;
        else             cnt_d   = cnt_q - CW'(1);
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sent_q <= 1'b0;
    end else if (sent_en) begin
      sent_q <= sent_d;
    end
  end

  // glitch-free registered gate outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      osc_q <= (phase_d == PH_BURST);
      clr_q <= (phase_d == PH_FLUSH);
    end
  end

  assign osc_en = osc_q;
  assign tx_clr = clr_q;

endmodule

// File: rtl/ebl_rx.sv
module ebl_rx
  import edge_burst_pkg::*;
#(
  parameter int RX_RST_CLKS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic det_s,
  output logic rx_rst,
  output logic data_out
);

  localparam int CW = cnt_width(RX_RST_CLKS);

  logic [CW-1:0] lock_q, lock_d;
  logic          lock_en;
  logic          busy;
  logic          flip;
  logic          lvl_q;
  logic          rst_q;

  assign busy = (lock_q != '0);

  // next-state logic
  always_comb begin
    lock_d  = lock_q;
    lock_en = 1'b0;
    flip    = 1'b0;
    if (busy) begin
      lock_d  = lock_q - CW'(1);
      lock_en = 1'b1;
    end else if (det_s) begin
      lock_d  = CW'(RX_RST_CLKS);
      lock_en = 1'b1;
      flip    = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '0;
    end else if (lock_en) begin
      lock_q <= lock_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
    end else if (flip) begin
      lvl_q <= ~lvl_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 1'b0;
    end else begin
      rst_q <= (lock_d != '0);
    end
  end

  assign rx_rst   = rst_q;
  assign data_out = lvl_q;

endmodule

// File: rtl/edge_burst_link.sv
module edge_burst_link
  import edge_burst_pkg::*;
#(
  parameter int CLKS_PER_CARRIER = 4,
  parameter int FAST_CHANNEL     = 1,
  parameter int CLR_CLKS         = 4,
  parameter int RX_RST_CLKS      = 6,
  parameter int SYNC_STAGES      = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic data_in,
  output logic osc_en,
  output logic tx_clr,
  input  logic det_in,
  output logic rx_rst,
  output logic data_out
);

  localparam int CARRIERS_PER_BURST = (FAST_CHANNEL != 0) ? 3 : 2;
  localparam int BURST_CLKS         = CARRIERS_PER_BURST * CLKS_PER_CARRIER;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  logic data_s;
  logic det_s;

  ebl_sync #(.STAGES(SYNC_STAGES)) u_sync_data (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (data_in),
    .q     (data_s)
  );

  ebl_sync #(.STAGES(SYNC_STAGES)) u_sync_det (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (det_in),
    .q     (det_s)
  );

  ebl_tx #(
    .BURST_CLKS (BURST_CLKS),
    .CLR_CLKS   (CLR_CLKS)
  ) u_tx (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .data_s (data_s),
    .osc_en (osc_en),
    .tx_clr (tx_clr)
  );

  ebl_rx #(
    .RX_RST_CLKS (RX_RST_CLKS)
  ) u_rx (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .det_s    (det_s),
    .rx_rst   (rx_rst),
    .data_out (data_out)
  );

endmodule

// File: rtl/ebl_chk.sv
module ebl_chk #(
  parameter int BURST_CLKS  = 12,
  parameter int CLR_CLKS    = 4,
  parameter int RX_RST_CLKS = 6
) (
  input logic clk,
  input logic rst_n,
  input logic osc_en,
  input logic tx_clr,
  input logic rx_rst,
  input logic data_out
);

  logic [15:0] osc_run_q, clr_run_q, rst_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_run_q <= '0;
      clr_run_q <= '0;
      rst_run_q <= '0;
    end else begin
      osc_run_q <= osc_en ? osc_run_q + 16'd1 : 16'd0;
      clr_run_q <= tx_clr ? clr_run_q + 16'd1 : 16'd0;
      rst_run_q <= rx_rst ? rst_run_q + 16'd1 : 16'd0;
    end
  end

  assert_burst_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en) |-> (osc_run_q == 16'(BURST_CLKS)));

  assert_clear_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en) |-> tx_clr);

  assert_clear_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_clr) |-> (clr_run_q == 16'(CLR_CLKS)));

  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(osc_en && tx_clr));

  assert_rst_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_rst) |-> (rst_run_q == 16'(RX_RST_CLKS)));

  assert_toggle_on_rst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_rst) |-> (data_out != $past(data_out)));

  assert_lockout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst |=> $stable(data_out));

endmodule

bind edge_burst_link ebl_chk #(
  .BURST_CLKS  (BURST_CLKS),
  .CLR_CLKS    (CLR_CLKS),
  .RX_RST_CLKS (RX_RST_CLKS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .osc_en   (osc_en),
  .tx_clr   (tx_clr),
  .rx_rst   (rx_rst),
  .data_out (data_out)
);

// File: tb/edge_burst_link_tb.sv
module edge_burst_link_tb;

  localparam int CPC = 4;
  localparam int CLR = 4;
  localparam int RXW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic data_in = 1'b0;
  logic det_in = 1'b0;
  logic osc_f, clr_f, rxr_f, dout_f;
  logic osc_s, clr_s, rxr_s, dout_s;

  always #10 clk = ~clk;

  edge_burst_link #(.CLKS_PER_CARRIER(CPC), .FAST_CHANNEL(1), .CLR_CLKS(CLR),
                    .RX_RST_CLKS(RXW), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .osc_en(osc_f), .tx_clr(clr_f),
    .det_in(det_in), .rx_rst(rxr_f), .data_out(dout_f));

  edge_burst_link #(.CLKS_PER_CARRIER(CPC), .FAST_CHANNEL(0), .CLR_CLKS(CLR),
                    .RX_RST_CLKS(RXW), .SYNC_STAGES(2)) u_slow (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .osc_en(osc_s), .tx_clr(clr_s),
    .det_in(det_in), .rx_rst(rxr_s), .data_out(dout_s));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  bit cmp_on = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference model: 0 idle, 1 burst, 2 clear
  int m_rel = 0;
  int dq[2], eq[2];
  int st[2], left[2], sent[2];
  int blen[2] = '{3 * CPC, 2 * CPC};
  int rleft = 0, mdout = 0;

  always @(posedge clk) begin
    if (!rst_n || m_rel < 2) begin
      if (!rst_n) m_rel = 0; else m_rel++;
      dq = '{0, 0}; eq = '{0, 0};
      st = '{0, 0}; left = '{0, 0}; sent = '{0, 0};
      rleft = 0; mdout = 0;
    end else begin
      int ds, es;
      ds = dq[1]; es = eq[1];
      dq[1] = dq[0]; dq[0] = int'(data_in);
      eq[1] = eq[0]; eq[0] = int'(det_in);
      for (int k = 0; k < 2; k++) begin
        if (st[k] == 0) begin
          if (ds != sent[k]) begin sent[k] = ds; st[k] = 1; left[k] = blen[k]; end
        end else if (st[k] == 1) begin
          left[k]--;
          if (left[k] == 0) begin st[k] = 2; left[k] = CLR; end
        end else begin
          left[k]--;
          if (left[k] == 0) st[k] = 0;
        end
      end
      if (rleft > 0) rleft--;
      else if (es != 0) begin mdout = 1 - mdout; rleft = RXW; end
    end
  end

  // per-cycle comparison and run measurement
  int runf = 0, lastf = 0, rises_f = 0, runs = 0, lasts = 0;
  int runc = 0, lastc = 0, rrun = 0, rlast = 0, dtog = 0;
  logic dprev = 1'b0, oprev = 1'b0;

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(osc_f == (st[0] == 1), "R3 osc_en fast", osc_f, int'(st[0] == 1));
      chk(osc_s == (st[1] == 1), "R3 osc_en slow", osc_s, int'(st[1] == 1));
      chk(clr_f == (st[0] == 2), "R4 tx_clr fast", clr_f, int'(st[0] == 2));
      chk(clr_s == (st[1] == 2), "R4 tx_clr slow", clr_s, int'(st[1] == 2));
      chk(rxr_f == (rleft > 0), "R6 rx_rst", rxr_f, int'(rleft > 0));
      chk(rxr_s == (rleft > 0), "R6 rx_rst slow", rxr_s, int'(rleft > 0));
      chk(dout_f == mdout[0], "R7 data_out", dout_f, mdout);
      chk(dout_s == mdout[0], "R7 data_out slow", dout_s, mdout);
    end
    if (osc_f) runf++; else if (runf > 0) begin lastf = runf; runf = 0; end
    if (osc_s) runs++; else if (runs > 0) begin lasts = runs; runs = 0; end
    if (clr_f) runc++; else if (runc > 0) begin lastc = runc; runc = 0; end
    if (rxr_f) rrun++; else if (rrun > 0) begin rlast = rrun; rrun = 0; end
    if (osc_f && !oprev) rises_f++;
    if (dout_f != dprev) dtog++;
    oprev = osc_f; dprev = dout_f;
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int r0, t0;
    logic d0;
    wait_n(4);
    chk(osc_f == 0 && clr_f == 0 && rxr_f == 0 && dout_f == 0, "R1 outputs in reset",
        {osc_f, clr_f, rxr_f, dout_f}, 0);
    rst_n = 1'b1; cmp_on = 1;
    wait_n(8);
    chk(rises_f == 0, "R1 no burst with data low", rises_f, 0);
    chk(dout_f == 0 && rxr_f == 0, "R1 rx idle", {rxr_f, dout_f}, 0);

    // R2 rising change, R3 and R4 lengths
    data_in = 1'b1;
    wait_n(2);
    chk(osc_f == 0, "R2 rise latency early", osc_f, 0);
    wait_n(1);
    chk(osc_f == 1, "R2 rise latency", osc_f, 1);
    wait_n(30);
    chk(lastf == 3 * CPC, "R3 fast burst length", lastf, 3 * CPC);
    chk(lasts == 2 * CPC, "R3 slow burst length", lasts, 2 * CPC);
    chk(lastc == CLR, "R4 clear length", lastc, CLR);

    // R2 falling change
    data_in = 1'b0;
    wait_n(2);
    chk(osc_f == 0, "R2 fall latency early", osc_f, 0);
    wait_n(1);
    chk(osc_f == 1, "R2 fall latency", osc_f, 1);
    wait_n(30);

    // R5 change during burst is held and sent afterwards
    r0 = rises_f;
    data_in = 1'b1; wait_n(4); data_in = 1'b0;
    wait_n(60);
    chk(rises_f - r0 == 2, "R5 pending change sent", rises_f - r0, 2);

    // R5 changes that cancel out during busy send nothing extra
    r0 = rises_f;
    data_in = 1'b1; wait_n(5); data_in = 1'b0; wait_n(2); data_in = 1'b1;
    wait_n(60);
    chk(rises_f - r0 == 1, "R5 net-zero change", rises_f - r0, 1);
    data_in = 1'b0; wait_n(60);

    // R6 and R7 single detection
    d0 = dout_f; t0 = dtog;
    det_in = 1'b1; wait_n(1); det_in = 1'b0;
    wait_n(1);
    chk(dout_f == d0, "R7 no toggle before latency", dout_f, d0);
    wait_n(1);
    chk(dout_f != d0, "R7 toggle on detection", dout_f, !d0);
    chk(rxr_f == 1, "R6 reset raised", rxr_f, 1);
    wait_n(20);
    chk(rlast == RXW, "R6 reset width", rlast, RXW);

    // R8 second detection inside reset is ignored
    t0 = dtog;
    det_in = 1'b1; wait_n(1); det_in = 1'b0; wait_n(2);
    det_in = 1'b1; wait_n(1); det_in = 1'b0;
    wait_n(20);
    chk(dtog - t0 == 1, "R8 detection ignored in reset", dtog - t0, 1);
    chk(rlast == RXW, "R8 reset not extended", rlast, RXW);

    // R6 detector held past the reset window is counted again
    t0 = dtog;
    det_in = 1'b1; wait_n(12); det_in = 1'b0;
    wait_n(20);
    chk(dtog - t0 == 2, "R6 held detector recounted", dtog - t0, 2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule